// File: doc/BRIEF.md
# Serial Unlock Pattern Recognizer

This block watches the chip-enabled cycles of a memory bus and looks for a fixed 64-bit unlock key. The key arrives one bit per write cycle on data bit 0. Each bus cycle reaches the block as a single-clock strobe with a read/write flag and the value of that data bit. A read re-arms the recognizer at the first key bit. Each matching write moves a pointer forward by one. A mismatching write parks the recognizer in a failed state, and it ignores every write until the next read.

When the 64th consecutive write matches, the block raises `unlocked`. That output hands the following bus cycles to a separate serial transfer engine. While it is high, the block also withholds the memory strobe, so the RAM sees none of those cycles. The transfer engine ends the unlocked period by pulsing its done or abort input. After that, a fresh read is needed before a new key can be accepted. Until the key is complete, every strobe passes through to memory in the same cycle.

Top module: `ukey_recognizer`

## Requirements
- R1: The key is the byte sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C. Each byte is sent least significant bit first, so transmitted bit i equals bit (i mod 8) of byte i/8. A write is a strobe with `cyc_wr`=1. `unlocked` is high one clock after the 64th consecutive matching write strobe. After only 63 matching writes it is still low.
- R2: While locked, a read strobe (`cyc_stb`=1, `cyc_wr`=0) sets the pointer to key bit 0 and clears the failed state. This also applies in the middle of a sequence, so a full key sent after such a read unlocks.
- R3: While locked and armed, a write whose bit matches the expected key bit advances the pointer by one. A mismatching write sets a sticky fail state and leaves the pointer in place. From then on, all writes are ignored until a read, so even the correct remainder of the key does not unlock.
- R4: While `unlocked` is low, `mem_stb` equals `cyc_stb` in the same cycle.
- R5: While `unlocked` is high, `mem_stb` stays low. Strobes of either kind leave `unlocked` and the recognition state unchanged.
- R6: Clocks without `cyc_stb` leave the pointer, the fail state and `unlocked` unchanged. Idle cycles inserted in the middle of a key do not break it.
- R7: While unlocked, a pulse on `xfer_done` or on `xfer_abort` clears `unlocked` one clock later. After that, writes are ignored until a read re-arms the recognizer.
- R8: While locked, `xfer_done` and `xfer_abort` have no effect.
- R9: Synchronous reset (`rst`=1) clears the pointer, the fail state and `unlocked`. After reset the recognizer is armed at key bit 0 without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_stb | input | 1 | One-clock strobe per chip-enabled bus cycle |
| cyc_wr | input | 1 | Cycle kind: 1 write, 0 read |
| cyc_dq0 | input | 1 | Data bit 0 of the cycle |
| xfer_done | input | 1 | Transfer engine finished its cycles |
| xfer_abort | input | 1 | Transfer engine aborted |
| unlocked | output | 1 | Key recognized; transfer engine owns the bus |
| mem_stb | output | 1 | Strobe forwarded to memory |

## Verification
`mem_stb` is combinational, so the bench drives each cycle at the falling edge and checks it 1 ns later, in the same cycle as the strobe. `unlocked` passes through one register. It is due one clock after the last key write or after a release pulse, so the bench samples it 1 ns after the rising edge that ends that cycle. Table rows expect their `unlocked` value only once their whole stimulus has gone through. Rows that stop one bit short of the key pin the due cycle to the exact edge.

// File: rtl/ukey_pkg.sv
package ukey_pkg;
  localparam int unsigned UK_KEY_MAX = 64;
  // Transmission order: bit i of this vector is the i-th bit sent.
  localparam logic [UK_KEY_MAX-1:0] UK_KEY_DEF = 64'h5CA3_3AC5_5CA3_3AC5;

  function automatic logic key_bit_at(input logic [UK_KEY_MAX-1:0] key,
                                      input int unsigned idx);
    return (idx < UK_KEY_MAX) ? key[idx] : 1'b0;
  endfunction

  function automatic int unsigned ptr_step(input int unsigned p);
    return p + 1;
  endfunction
endpackage

// File: rtl/ukey_bit_sel.sv
module ukey_bit_sel
  import ukey_pkg::*;
#(
  parameter int unsigned KEY_LEN = 64,
  parameter logic [UK_KEY_MAX-1:0] KEY = UK_KEY_DEF,
  parameter int unsigned PTR_W = $clog2(KEY_LEN)
) (
  input  logic [PTR_W-1:0] ptr,
  output logic             exp_bit,
  output logic             is_last
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(KEY_LEN - 1);

  generate
    if (KEY_LEN == (1 << PTR_W)) begin : g_full
      always_comb exp_bit = key_bit_at(KEY, int'(ptr));
    end else begin : g_guard
      always_comb exp_bit = (int'(ptr) < KEY_LEN) ? key_bit_at(KEY, int'(ptr)) : 1'b0;
    end
  endgenerate

  assign is_last = (ptr == LAST_IDX);
endmodule

// File: rtl/ukey_tracker.sv
module ukey_tracker #(
  parameter int unsigned PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_read,
  input  logic             evt_hit,
  input  logic             evt_miss,
  input  logic             evt_last,
  output logic [PTR_W-1:0] ptr,
  output logic             fail
);
  import ukey_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      fail <= 1'b0;
    end else if (evt_read) begin
      ptr  <= '0;
      fail <= 1'b0;
    end else if (evt_last) begin
      ptr  <= '0;
      fail <= 1'b1;
    end else if (evt_hit) begin
      ptr  <= PTR_W'(ptr_step(int'(ptr)));
    end else if (evt_miss) begin
      fail <= 1'b1;
    end
  end
endmodule

// File: rtl/ukey_gate.sv
module ukey_gate (
  input  logic clk,
  input  logic rst,
  input  logic evt_last,
  input  logic evt_release,
  input  logic cyc_stb,
  output logic unlocked,
  output logic mem_stb
);
  always_ff @(posedge clk) begin
    if (rst)              unlocked <= 1'b0;
    else if (evt_release) unlocked <= 1'b0;
    else if (evt_last)    unlocked <= 1'b1;
  end

  assign mem_stb = cyc_stb & ~unlocked;
endmodule

// File: rtl/ukey_recognizer.sv
module ukey_recognizer
  import ukey_pkg::*;
#(
  parameter int unsigned KEY_LEN = 64,
  parameter logic [UK_KEY_MAX-1:0] KEY = UK_KEY_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_stb,
  input  logic cyc_wr,
  input  logic cyc_dq0,
  input  logic xfer_done,
  input  logic xfer_abort,
  output logic unlocked,
  output logic mem_stb
);
  localparam int unsigned PTR_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

  logic [PTR_W-1:0] ptr;
  logic             fail;
  logic             exp_bit;
  logic             is_last;

  // Named internal events, also watched by the checker.
  logic locked;
  logic evt_read;
  logic evt_wr_armed;
  logic evt_hit;
  logic evt_miss;
  logic evt_last;
  logic evt_release;

  assign locked       = ~unlocked;
  assign evt_read     = cyc_stb & ~cyc_wr & locked;
  assign evt_wr_armed = cyc_stb & cyc_wr & locked & ~fail;
  assign evt_hit      = evt_wr_armed & (cyc_dq0 == exp_bit);
  assign evt_miss     = evt_wr_armed & (cyc_dq0 != exp_bit);
  assign evt_last     = evt_hit & is_last;
  assign evt_release  = unlocked & (xfer_done | xfer_abort);

  ukey_bit_sel #(.KEY_LEN(KEY_LEN), .KEY(KEY), .PTR_W(PTR_W)) sel_i (
    .ptr(ptr), .exp_bit(exp_bit), .is_last(is_last)
  );

  ukey_tracker #(.PTR_W(PTR_W)) trk_i (
    .clk(clk), .rst(rst), .evt_read(evt_read), .evt_hit(evt_hit),
    .evt_miss(evt_miss), .evt_last(evt_last), .ptr(ptr), .fail(fail)
  );

  ukey_gate gate_i (
    .clk(clk), .rst(rst), .evt_last(evt_last), .evt_release(evt_release),
    .cyc_stb(cyc_stb), .unlocked(unlocked), .mem_stb(mem_stb)
  );
endmodule

// File: rtl/ukey_recognizer_chk.sv
module ukey_recognizer_chk #(
  parameter int unsigned PTR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_stb,
  input logic             cyc_wr,
  input logic             xfer_done,
  input logic             xfer_abort,
  input logic             unlocked,
  input logic             mem_stb,
  input logic [PTR_W-1:0] ptr,
  input logic             fail,
  input logic             evt_hit,
  input logic             evt_miss,
  input logic             evt_last
);
  p_unlock_after_last_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(evt_last));

  p_read_rearms_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && !cyc_wr && !unlocked) |=> (ptr == '0) && !fail);

  p_hit_advances_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_hit && !evt_last) |=> ptr == PTR_W'($past(ptr) + 1'b1));

  p_miss_sticks_r3: assert property (@(posedge clk) disable iff (rst)
    evt_miss |=> fail && $stable(ptr));

  p_pass_through_r4: assert property (@(posedge clk) disable iff (rst)
    !unlocked |-> (mem_stb == cyc_stb));

  p_block_mem_r5: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> !mem_stb);

  p_frozen_unlocked_r5: assert property (@(posedge clk) disable iff (rst)
    (unlocked && !xfer_done && !xfer_abort) |=> unlocked && $stable(ptr) && $stable(fail));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!cyc_stb && !xfer_done && !xfer_abort) |=> $stable(ptr) && $stable(fail) && $stable(unlocked));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (unlocked && (xfer_done || xfer_abort)) |=> !unlocked && fail);

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (ptr == '0) && !fail && !unlocked);
endmodule

bind ukey_recognizer ukey_recognizer_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .cyc_wr(cyc_wr),
  .xfer_done(xfer_done), .xfer_abort(xfer_abort), .unlocked(unlocked),
  .mem_stb(mem_stb), .ptr(ptr), .fail(fail), .evt_hit(evt_hit),
  .evt_miss(evt_miss), .evt_last(evt_last)
);

// File: tb/ukey_recognizer_tb.sv
module ukey_recognizer_tb_top;
  logic clk = 1'b0;
  logic rst, cyc_stb, cyc_wr, cyc_dq0, xfer_done, xfer_abort;
  logic unlocked, mem_stb;
  int   n_chk = 0;
  int   n_err = 0;

  always #5 clk = ~clk;

  ukey_recognizer dut_i (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .cyc_wr(cyc_wr), .cyc_dq0(cyc_dq0),
    .xfer_done(xfer_done), .xfer_abort(xfer_abort),
    .unlocked(unlocked), .mem_stb(mem_stb)
  );

  // Key model (R1): byte list, each byte sent LSB first.
  function automatic logic kbit(input int i);
    logic [7:0] b;
    case ((i / 8) % 4)
      0: b = 8'hC5;
      1: b = 8'h3A;
      2: b = 8'hA3;
      default: b = 8'h5C;
    endcase
    return b[i % 8];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One bus clock; mem_stb is checked in the same cycle (R4 or R5).
  task automatic cyc(input logic s, input logic w, input logic d,
                     input logic dn, input logic ab);
    @(negedge clk);
    cyc_stb = s; cyc_wr = w; cyc_dq0 = d; xfer_done = dn; xfer_abort = ab;
    #1;
    if (s) begin
      if (unlocked) chk("R5 mem_stb", mem_stb, 1'b0);
      else          chk("R4 mem_stb", mem_stb, 1'b1);
    end
    @(posedge clk);
    #1;
    cyc_stb = 1'b0; cyc_wr = 1'b0; cyc_dq0 = 1'b0; xfer_done = 1'b0; xfer_abort = 1'b0;
  endtask

  task automatic send_key(input int from, input int upto);
    for (int i = from; i < upto; i++) cyc(1'b1, 1'b1, kbit(i), 1'b0, 1'b0);
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
  endtask

  localparam logic [2:0] OP_READ = 3'd0, OP_KEY = 3'd1, OP_BAD = 3'd2,
                         OP_IDLE = 3'd3, OP_DONE = 3'd4, OP_ABORT = 3'd5;
  localparam int NROW = 29;
  // Row: op, a, b, expected unlocked after the row, requirement number.
  localparam logic [21:0] TBL [0:NROW-1] = '{
    {OP_KEY,   7'd0,  7'd64, 1'b1, 4'd9}, // R9 armed after reset without read
    {OP_DONE,  7'd0,  7'd0,  1'b0, 4'd7}, // R7 release by done
    {OP_KEY,   7'd0,  7'd64, 1'b0, 4'd7}, // R7 needs a read after release
    {OP_READ,  7'd0,  7'd0,  1'b0, 4'd2},
    {OP_KEY,   7'd0,  7'd64, 1'b1, 4'd1}, // R1 full key
    {OP_READ,  7'd0,  7'd0,  1'b1, 4'd5}, // R5 read while unlocked ignored
    {OP_ABORT, 7'd0,  7'd0,  1'b0, 4'd7}, // R7 release by abort
    {OP_READ,  7'd0,  7'd0,  1'b0, 4'd2},
    {OP_KEY,   7'd0,  7'd20, 1'b0, 4'd6},
    {OP_IDLE,  7'd5,  7'd0,  1'b0, 4'd6}, // R6 idle gap mid-key
    {OP_KEY,   7'd20, 7'd64, 1'b1, 4'd6},
    {OP_DONE,  7'd0,  7'd0,  1'b0, 4'd7},
    {OP_READ,  7'd0,  7'd0,  1'b0, 4'd2},
    {OP_KEY,   7'd0,  7'd30, 1'b0, 4'd3},
    {OP_BAD,   7'd30, 7'd0,  1'b0, 4'd3}, // R3 mismatch
    {OP_KEY,   7'd31, 7'd64, 1'b0, 4'd3}, // R3 later writes ignored
    {OP_KEY,   7'd30, 7'd64, 1'b0, 4'd3}, // R3 correct remainder ignored
    {OP_READ,  7'd0,  7'd0,  1'b0, 4'd2},
    {OP_KEY,   7'd0,  7'd10, 1'b0, 4'd2},
    {OP_READ,  7'd0,  7'd0,  1'b0, 4'd2}, // R2 read mid-key restarts
    {OP_KEY,   7'd0,  7'd64, 1'b1, 4'd2},
    {OP_DONE,  7'd0,  7'd0,  1'b0, 4'd7},
    {OP_READ,  7'd0,  7'd0,  1'b0, 4'd2},
    {OP_DONE,  7'd0,  7'd0,  1'b0, 4'd8}, // R8 done while locked
    {OP_ABORT, 7'd0,  7'd0,  1'b0, 4'd8}, // R8 abort while locked
    {OP_KEY,   7'd0,  7'd64, 1'b1, 4'd8},
    {OP_ABORT, 7'd0,  7'd0,  1'b0, 4'd7},
    {OP_KEY,   7'd0,  7'd63, 1'b0, 4'd1}, // R1 boundary: 63 bits (after read below)
    {OP_KEY,   7'd63, 7'd64, 1'b1, 4'd1}  // R1 64th bit unlocks
  };

  initial begin
    rst = 1'b1; cyc_stb = 1'b0; cyc_wr = 1'b0; cyc_dq0 = 1'b0;
    xfer_done = 1'b0; xfer_abort = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R9 reset unlocked", unlocked, 1'b0);
    chk("R9 reset mem_stb", mem_stb, 1'b0);

    for (int r = 0; r < NROW; r++) begin
      logic [2:0] op;
      int a, b;
      op = TBL[r][21:19];
      a  = int'(TBL[r][18:12]);
      b  = int'(TBL[r][11:5]);
      if (r == 27) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // re-arm for R1 boundary
      case (op)
        OP_READ:  cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        OP_KEY:   send_key(a, b);
        OP_BAD:   cyc(1'b1, 1'b1, ~kbit(a), 1'b0, 1'b0);
        OP_IDLE:  for (int k = 0; k < a; k++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        OP_DONE:  cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        default:  cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      endcase
      chk($sformatf("R%0d row %0d unlocked", TBL[r][3:0], r), unlocked, TBL[r][4]);
    end

    // R9: reset while unlocked
    pulse_rst();
    chk("R9 reset while unlocked", unlocked, 1'b0);
    // R9: reset mid-key clears the pointer; a whole key then unlocks
    send_key(0, 40);
    pulse_rst();
    send_key(0, 64);
    chk("R9 pointer cleared by reset", unlocked, 1'b1);
    // R5: writes while unlocked do not change state
    send_key(0, 8);
    chk("R5 writes ignored while unlocked", unlocked, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R4: no strobe means no memory strobe
    @(negedge clk); #1;
    chk("R4 idle mem_stb", mem_stb, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule